// File: doc/BRIEF.md
# Timer Compare Output Mode Generator

This block produces the output reference level of one timer channel. Each cycle in which the counter advances, it compares the counter value with the channel's compare value. A 3-bit mode field then selects the action: hold the level, set it on a match, clear it on a match, toggle it on a match, force it low, force it high, or one of two pulse-width modes. The counter, prescaler, polarity control, output enables and complementary outputs are separate blocks around it.

An external clear input is gated by its own enable. When that clear is asserted, the reference goes low. It then stays low until the next update event, even after the clear input drops. The reference is a register, so every change appears one clock after the condition that causes it.

Top module: `tmr_cmp_out`

## Requirements
- R1: While `rst_ni` is low, `ref_o` is 0 and the external-clear hold is cleared.
- R2: In mode 3'b000, `ref_o` keeps its current level, whether or not the counter matches the compare value.
- R3: In mode 3'b001, `ref_o` goes to 1 one clock after a cycle with `cnt_en_i`=1 and `cnt_i`==`cmp_i`. In mode 3'b010, it goes to 0 in the same way. In cycles with no match, the level is kept.
- R4: In mode 3'b011, `ref_o` inverts one clock after each cycle with `cnt_en_i`=1 and `cnt_i`==`cmp_i`.
- R5: Mode 3'b100 drives `ref_o` to 0 and mode 3'b101 drives it to 1 on the next clock. This ignores the comparison and the state of `cnt_en_i`.
- R6: In mode 3'b110, after each cycle with `cnt_en_i`=1, `ref_o` equals (`cnt_i` < `cmp_i`). The count direction has no effect, and a compare value of 0 keeps `ref_o` at 0.
- R7: In mode 3'b111, after each cycle with `cnt_en_i`=1, `ref_o` equals (`cnt_i` >= `cmp_i`). A compare value above every count reached keeps mode 3'b111 at 0 and mode 3'b110 at 1.
- R8: When `clr_en_i`=1 and `ext_clr_i`=1, `ref_o` is 0 on the next clock in every mode. When `clr_en_i`=0, `ext_clr_i` has no effect.
- R9: After an external clear, `ref_o` stays 0 until a cycle with `upd_i`=1 and no active clear. In that cycle the mode logic applies again.
- R10: In modes 3'b000 to 3'b011, 3'b110 and 3'b111, `ref_o` does not change in a cycle with `cnt_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter clock enable; the comparison is evaluated only in these cycles |
| cnt_i | input | CNT_W | Current counter value |
| cmp_i | input | CNT_W | Channel compare value |
| mode_i | input | 3 | Output mode select |
| clr_en_i | input | 1 | Enable for the external clear |
| ext_clr_i | input | 1 | External clear request, active high |
| upd_i | input | 1 | Update-event strobe; releases a held clear |
| ref_o | output | 1 | Registered output reference level |

## Verification
On every cycle, the assertions check four things. An enabled external clear and a held clear both give a low reference on the next clock. The forced-high mode and the toggle mode act on the next clock. A PWM-mode-0 cycle below the compare value sets the reference. An idle cycle in a compare or PWM mode leaves the reference unchanged. The bench scenarios show the rest. These are the counter sweeps in both directions, the compare-value extremes, and a clear input that is ignored while its enable is low. They also show the release of a held clear exactly on the update cycle.

// File: rtl/tmr_cmp_pkg.sv
`timescale 1ns/1ps
package tmr_cmp_pkg;
  typedef enum logic [2:0] {
    MD_FROZEN = 3'b000,
    MD_SET    = 3'b001,
    MD_CLR    = 3'b010,
    MD_TGL    = 3'b011,
    MD_FRC_LO = 3'b100,
    MD_FRC_HI = 3'b101,
    MD_PWM0   = 3'b110,
    MD_PWM1   = 3'b111
  } cmp_mode_e;
endpackage

// File: rtl/tmr_cmp_match.sv
`timescale 1ns/1ps
module tmr_cmp_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             eq_o,
  output logic             lt_o
);
  assign eq_o = (cnt_i == cmp_i);
  assign lt_o = (cnt_i < cmp_i);
endmodule

// File: rtl/tmr_cmp_clr.sv
`timescale 1ns/1ps
module tmr_cmp_clr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic upd_i,
  output logic hold_o,
  output logic act_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= 1'b0;
    else if (set_i) hold_q <= 1'b1;
    else if (upd_i) hold_q <= 1'b0;
  end

  // update releases the hold in the same cycle
  assign act_o  = set_i | (hold_q & ~upd_i);
  assign hold_o = hold_q;

  a_r9_set_then_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> hold_o);
endmodule

// File: rtl/tmr_cmp_out.sv
`timescale 1ns/1ps
module tmr_cmp_out
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [2:0]       mode_i,
  input  logic             clr_en_i,
  input  logic             ext_clr_i,
  input  logic             upd_i,
  output logic             ref_o
);
  cmp_mode_e mode;
  logic eq, lt, clr_set, clr_hold, clr_act;
  logic ref_q, ref_d;

  assign mode    = cmp_mode_e'(mode_i);
  assign clr_set = clr_en_i & ext_clr_i;

  tmr_cmp_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i (cnt_i),
    .cmp_i (cmp_i),
    .eq_o  (eq),
    .lt_o  (lt)
  );

  tmr_cmp_clr u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (clr_set),
    .upd_i  (upd_i),
    .hold_o (clr_hold),
    .act_o  (clr_act)
  );

  always_comb begin
    ref_d = ref_q;
    if (clr_act) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode)
        MD_FRC_LO: ref_d = 1'b0;
        MD_FRC_HI: ref_d = 1'b1;
        default: if (cnt_en_i) begin
          unique case (mode)
            MD_SET:  if (eq) ref_d = 1'b1;
            MD_CLR:  if (eq) ref_d = 1'b0;
            MD_TGL:  if (eq) ref_d = ~ref_q;
            MD_PWM0: ref_d = lt;
            MD_PWM1: ref_d = ~lt;
            default: ref_d = ref_q;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  a_r8_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && ext_clr_i) |=> !ref_o);

  a_r9_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hold && !upd_i) |=> !ref_o);

  a_r5_force_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b101 && !clr_act) |=> ref_o);

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b011 && cnt_en_i && eq && !clr_act) |=> (ref_o != $past(ref_o)));

  a_r6_pwm0_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b110 && cnt_en_i && lt && !clr_act) |=> ref_o);

  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !clr_act && mode_i != 3'b100 && mode_i != 3'b101) |=> $stable(ref_o));
endmodule

// File: tb/sim_tmr_cmp_out.sv
`timescale 1ns/1ps
module sim_tmr_cmp_out;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, clr_en = 1'b0, ext = 1'b0, upd = 1'b0;
  logic [W-1:0] cnt = '0, cmp = '0;
  logic [2:0] mode = 3'b000;
  logic ref_w;

  int total = 0, bad = 0;
  logic m_ref = 1'b0, m_hold = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  tmr_cmp_out #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .cnt_i(cnt), .cmp_i(cmp),
    .mode_i(mode), .clr_en_i(clr_en), .ext_clr_i(ext), .upd_i(upd), .ref_o(ref_w)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: ref_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the predicted output
  task automatic step(input logic e, input logic [W-1:0] c, input logic [W-1:0] k,
                      input logic [2:0] md, input logic ce, input logic x,
                      input logic u, input string tag);
    logic set, act, nxt;
    item_t it;
    @(negedge clk);
    en = e; cnt = c; cmp = k; mode = md; clr_en = ce; ext = x; upd = u;
    set = ce & x;
    act = set | (m_hold & ~u);
    nxt = m_ref;
    if (act) nxt = 1'b0;
    else if (md == 3'b100) nxt = 1'b0;
    else if (md == 3'b101) nxt = 1'b1;
    else if (e) begin
      case (md)
        3'b001: if (c == k) nxt = 1'b1;
        3'b010: if (c == k) nxt = 1'b0;
        3'b011: if (c == k) nxt = ~m_ref;
        3'b110: nxt = (c < k);
        3'b111: nxt = !(c < k);
        default: nxt = m_ref;
      endcase
    end
    if (set) m_hold = 1'b1;
    else if (u) m_hold = 1'b0;
    m_ref = nxt;
    it.exp = nxt; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sweep(input logic [2:0] md, input logic [W-1:0] k,
                       input int lo, input int hi, input string tag);
    for (int i = lo; i <= hi; i++) step(1'b1, W'(i), k, md, 1'b0, 1'b0, 1'b0, tag);
    for (int i = hi; i >= lo; i--) step(1'b1, W'(i), k, md, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(ref_w, it.exp, it.tag);
      end
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: ref_o=%b expected=done", ref_w);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ref_w, 1'b0, "R1 reset");
    rst_n = 1'b1;
    sweep(3'b000, 8'd4, 0, 8, "R2 frozen low");
    step(1'b0, 8'd0, 8'd0, 3'b101, 1'b0, 1'b0, 1'b0, "R5 force high idle");
    sweep(3'b000, 8'd4, 0, 8, "R2 frozen high");
    step(1'b1, 8'd4, 8'd9, 3'b100, 1'b0, 1'b0, 1'b0, "R5 force low");
    sweep(3'b001, 8'd5, 0, 9, "R3 set on match");
    sweep(3'b010, 8'd3, 0, 9, "R3 clear on match");
    sweep(3'b011, 8'd6, 0, 9, "R4 toggle");
    sweep(3'b110, 8'd4, 0, 10, "R6 pwm0");
    sweep(3'b110, 8'd0, 0, 10, "R6 pwm0 zero compare");
    sweep(3'b111, 8'd4, 0, 10, "R7 pwm1");
    sweep(3'b110, 8'd200, 0, 20, "R7 pwm0 compare above range");
    sweep(3'b111, 8'd200, 0, 20, "R7 pwm1 compare above range");
    step(1'b1, 8'd9, 8'd4, 3'b111, 1'b0, 1'b0, 1'b0, "R7 pwm1 high");
    for (int i = 0; i < 4; i++) step(1'b0, 8'd1, 8'd4, 3'b111, 1'b0, 1'b0, 1'b0, "R10 idle pwm1");
    for (int i = 0; i < 4; i++) step(1'b0, 8'd4, 8'd4, 3'b010, 1'b0, 1'b0, 1'b0, "R10 idle clear mode");
    step(1'b1, 8'd1, 8'd4, 3'b110, 1'b0, 1'b0, 1'b0, "R6 pwm0 high");
    for (int i = 0; i < 3; i++) step(1'b1, W'(i), 8'd4, 3'b110, 1'b0, 1'b1, 1'b0, "R8 clear disabled");
    step(1'b1, 8'd1, 8'd4, 3'b110, 1'b1, 1'b1, 1'b0, "R8 clear active");
    step(1'b1, 8'd2, 8'd4, 3'b110, 1'b1, 1'b1, 1'b1, "R8 clear beats update");
    for (int i = 0; i < 4; i++) step(1'b1, W'(i), 8'd4, 3'b110, 1'b1, 1'b0, 1'b0, "R9 held low");
    step(1'b0, 8'd0, 8'd0, 3'b101, 1'b1, 1'b0, 1'b0, "R9 held over force");
    step(1'b1, 8'd1, 8'd4, 3'b110, 1'b1, 1'b0, 1'b1, "R9 release on update");
    step(1'b1, 8'd2, 8'd4, 3'b110, 1'b1, 1'b0, 1'b0, "R9 after release");
    step(1'b1, 8'd1, 8'd4, 3'b011, 1'b1, 1'b1, 1'b0, "R8 clear in toggle");
    step(1'b1, 8'd4, 8'd4, 3'b011, 1'b0, 1'b0, 1'b1, "R9 update then toggle");
    step(1'b1, 8'd4, 8'd4, 3'b011, 1'b0, 1'b0, 1'b0, "R4 toggle back");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule